// File: doc/BRIEF.md
# Transmit Block DMA Engine

This engine fetches one block of outgoing bytes from a memory bus and pushes them, in address order, into the transmit FIFO of a serial controller. Software writes a 24-bit start address and a 16-bit length through a byte-wide register port, sets the enable bit in the mode register and then writes a command. One command leaves the message open so that a later buffer can continue it. The other marks the final byte of the block as the end of the message.

Each byte is fetched as a single-beat burst. The engine raises a request, holds the address until the bus grants it, waits for the read data and then pushes the byte into the FIFO. While the FIFO reports full, the engine holds the byte and does not lose it. When the whole block has been pushed, the engine pulses a done interrupt, and software may then supply the next buffer. A zero length finishes at once without touching the bus. A command that arrives while a block is in flight is dropped and sets a sticky error flag.

Top module: `txdma_engine`

## Requirements
- R1: After reset, mem_req, fifo_wr, done_irq and cmd_err are all low and the enable bit is clear.
- R2: Register offsets: 0, 1 and 2 hold the low, middle and high bytes of the start address. 3 and 4 hold the low and high bytes of the length. Bit 0 of offset 5 is the DMA enable. A write to offset 6 is a command: bit 0 means transmit, bit 1 means transmit with end of message, and bit 1 wins when both bits are set.
- R3: An accepted command reads exactly the programmed number of bytes, at consecutive addresses from the start address, with the address wrapping modulo 2^24.
- R4: Once mem_req is raised it stays high, with mem_addr unchanged, until mem_gnt is seen high at a clock edge. Each grant moves exactly one byte.
- R5: Bytes enter the FIFO in fetch order with the data that was read. fifo_wr is never high while fifo_full is high, and a full FIFO delays bytes without dropping any.
- R6: With the end-of-message command, fifo_eom is high on the last byte pushed and on no other byte. With the plain command, fifo_eom is low on every push.
- R7: done_irq is a one-cycle pulse in the cycle after the clock edge that pushes the final byte.
- R8: A length of zero pulses done_irq in the second cycle after the command write edge, and mem_req is never raised.
- R9: A command written while a block is in flight changes nothing in the running transfer and sets cmd_err, which stays set until reset.
- R10: A command written while the enable bit is clear starts nothing, raises no interrupt and leaves cmd_err unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 24 | Memory read byte address |
| mem_gnt | input | 1 | Bus grant; accepts the pending request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| fifo_wr | output | 1 | FIFO push strobe |
| fifo_data | output | 8 | Byte to push |
| fifo_eom | output | 1 | End-of-message flag that goes with the pushed byte |
| fifo_full | input | 1 | FIFO cannot accept a byte this cycle |
| done_irq | output | 1 | Block-done interrupt pulse |
| cmd_err | output | 1 | Sticky flag for a command that was dropped because the engine was busy |

## Verification
A command write at edge E arms the engine at E, and the first request is visible after E+1. A zero-length block pulses done_irq after E+1, so the bench looks for it at the falling edge that follows E+1. Each push is compared against a queue of expected bytes and flags at the falling edge where fifo_wr is high. done_irq is then required at the very next falling edge and nowhere else. Addresses are checked at every rising edge where request and grant are both high, cmd_err is sampled at the falling edge right after the offending write, and grant, FIFO-full and read latency are randomised so that stalls land in every state.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam int TXD_ADDR_W = 24;
  localparam int TXD_CNT_W  = 16;
  localparam int TXD_REG_AW = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_PUSH = 2'd3
  } txd_state_t;
endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
  import txdma_pkg::*;
#(
  parameter int ADDR_W = TXD_ADDR_W,
  parameter int CNT_W  = TXD_CNT_W,
  parameter int REG_AW = TXD_REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] base,
  output logic [CNT_W-1:0]  count,
  output logic              start,
  output logic              start_eom,
  output logic              cmd_err
);
  localparam int AB       = ADDR_W / 8;
  localparam int CB       = CNT_W / 8;
  localparam int OFF_CNT  = AB;
  localparam int OFF_MODE = AB + CB;
  localparam int OFF_CMD  = AB + CB + 1;

  logic dma_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      base      <= '0;
      count     <= '0;
      dma_en    <= 1'b0;
      start     <= 1'b0;
      start_eom <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      start <= 1'b0;
      if (reg_wr) begin
        for (int i = 0; i < AB; i++)
          if (reg_addr == REG_AW'(i)) base[8*i +: 8] <= reg_wdata;
        for (int j = 0; j < CB; j++)
          if (reg_addr == REG_AW'(OFF_CNT + j)) count[8*j +: 8] <= reg_wdata;
        if (reg_addr == REG_AW'(OFF_MODE)) dma_en <= reg_wdata[0];
        if (reg_addr == REG_AW'(OFF_CMD) && dma_en && (reg_wdata[0] || reg_wdata[1])) begin
          if (busy || start) cmd_err <= 1'b1;
          else begin
            start     <= 1'b1;
            start_eom <= reg_wdata[1];
          end
        end
      end
    end
  end

  // R9: error flag never clears outside reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cmd_err |=> cmd_err);
  // R9: no new start while a block is in flight
  a_r9_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> !start);
endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
#(
  parameter int ADDR_W = TXD_ADDR_W,
  parameter int CNT_W  = TXD_CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_eom,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  count,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              fifo_wr,
  output logic [7:0]        fifo_data,
  output logic              fifo_eom,
  input  logic              fifo_full,
  output logic              done_irq
);
  txd_state_t        st;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic              eom_cmd;
  logic              last_q;
  logic [7:0]        data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      addr_q   <= '0;
      rem_q    <= '0;
      eom_cmd  <= 1'b0;
      last_q   <= 1'b0;
      data_q   <= '0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          addr_q  <= base;
          rem_q   <= count;
          eom_cmd <= start_eom;
          if (count == '0) done_irq <= 1'b1;
          else             st       <= ST_REQ;
        end
        ST_REQ: if (mem_gnt) st <= ST_WAIT;
        ST_WAIT: if (mem_rvalid) begin
          data_q <= mem_rdata;
          last_q <= (rem_q == CNT_W'(1));
          st     <= ST_PUSH;
        end
        ST_PUSH: if (!fifo_full) begin
          addr_q <= addr_q + ADDR_W'(1);
          rem_q  <= rem_q - CNT_W'(1);
          if (last_q) begin
            st       <= ST_IDLE;
            done_irq <= 1'b1;
          end else begin
            st <= ST_REQ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign mem_req   = (st == ST_REQ);
  assign mem_addr  = addr_q;
  assign fifo_wr   = (st == ST_PUSH) && !fifo_full;
  assign fifo_data = data_q;
  assign fifo_eom  = last_q && eom_cmd;

  // R4: request held with a stable address until granted
  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));
  // R5: no push into a full FIFO
  a_r5_no_push_full: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !fifo_wr);
  // R6: end-of-message push is the final one of the block
  a_r6_eom_last: assert property (@(posedge clk) disable iff (rst)
    fifo_wr && fifo_eom |=> done_irq);
  // R7: done is a single-cycle pulse
  a_r7_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);
  // R7: engine is quiet when it reports done
  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> !mem_req && !fifo_wr);
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
  import txdma_pkg::*;
#(
  parameter int ADDR_W = TXD_ADDR_W,
  parameter int CNT_W  = TXD_CNT_W,
  parameter int REG_AW = TXD_REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              fifo_wr,
  output logic [7:0]        fifo_data,
  output logic              fifo_eom,
  input  logic              fifo_full,
  output logic              done_irq,
  output logic              cmd_err
);
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  count;
  logic              start, start_eom, busy;

  txdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .base(base), .count(count),
    .start(start), .start_eom(start_eom), .cmd_err(cmd_err)
  );

  txdma_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_eom(start_eom),
    .base(base), .count(count), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_eom(fifo_eom),
    .fifo_full(fifo_full), .done_irq(done_irq)
  );
endmodule

// File: tb/tb_txdma_engine.sv
`timescale 1ns/1ps
module tb_txdma_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        fifo_wr;
  logic [7:0]  fifo_data;
  logic        fifo_eom;
  logic        fifo_full = 1'b0;
  logic        done_irq;
  logic        cmd_err;

  always #5 clk = ~clk;

  txdma_engine dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_eom(fifo_eom),
    .fifo_full(fifo_full), .done_irq(done_irq), .cmd_err(cmd_err)
  );

  int n_chk = 0, n_fail = 0;
  int full_pct = 0;
  int req_cycles = 0;
  int accepted = 0;
  int pend = 0;
  logic [7:0]  pdata;
  logic [23:0] next_addr = '0;
  bit en_model = 0, busy_model = 0, irq_next = 0;
  logic [8:0] exp_q[$];

  function automatic logic [7:0] memf(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[20:16], a[23:21]} ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus and FIFO environment
  always @(posedge clk) begin
    mem_gnt   <= ($urandom % 3) != 0;
    fifo_full <= ($urandom % 100) < full_pct;
  end

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= pdata;
      end
    end
    if (!rst && mem_req && mem_gnt) begin
      chk(mem_addr == next_addr, "R3", "read address", 32'(mem_addr), 32'(next_addr));
      next_addr = next_addr + 24'd1;
      accepted++;
      pdata = memf(mem_addr);
      pend  = 1 + ($urandom % 2);
    end
  end

  // per-cycle comparison against the expected stream
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req) req_cycles++;
      if (irq_next) begin
        chk(done_irq == 1'b1, "R7", "done pulse due", 32'(done_irq), 32'd1);
        irq_next   = 0;
        busy_model = 0;
      end else if (done_irq) begin
        chk(1'b0, "R7", "unexpected done pulse", 32'd1, 32'd0);
      end
      if (fifo_wr) begin
        if (fifo_full) chk(1'b0, "R5", "push while full", 32'd1, 32'd0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected push", 32'(fifo_data), 32'd0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(fifo_data == e[7:0], "R5", "push data", 32'(fifo_data), 32'(e[7:0]));
          chk(fifo_eom == e[8], "R6", "eom flag", 32'(fifo_eom), 32'(e[8]));
          if (exp_q.size() == 0) irq_next = 1;
        end
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic program_blk(input logic [23:0] b, input logic [15:0] n);
    wr_reg(3'd0, b[7:0]);
    wr_reg(3'd1, b[15:8]);
    wr_reg(3'd2, b[23:16]);
    wr_reg(3'd3, n[7:0]);
    wr_reg(3'd4, n[15:8]);
  endtask

  // R2: command byte at offset 6, bit1 (end of message) wins over bit0
  task automatic issue_cmd(input logic [23:0] b, input logic [15:0] n, input logic [7:0] c);
    bit acc;
    acc = en_model && !busy_model && (c[0] || c[1]);
    if (acc) begin
      busy_model = 1;
      next_addr  = b;
      accepted   = 0;
      for (int i = 0; i < n; i++)
        exp_q.push_back({c[1] && (i == n - 1), memf(b + 24'(i))});
    end
    wr_reg(3'd6, c);
    if (acc && n == 0) begin
      @(posedge clk);
      irq_next = 1;
    end
  endtask

  task automatic wait_idle(input int n, input string req);
    for (int k = 0; k < 20000 && busy_model; k++) @(negedge clk);
    chk(!busy_model, req, "block completed", 32'(busy_model), 32'd0);
    chk(accepted == n, "R3", "bytes fetched", 32'(accepted), 32'(n));
    repeat (3) @(negedge clk);
  endtask

  task automatic run_blk(input logic [23:0] b, input logic [15:0] n, input logic [7:0] c,
                         input string req);
    program_blk(b, n);
    issue_cmd(b, n, c);
    wait_idle(n, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(!mem_req && !fifo_wr && !done_irq, "R1", "outputs idle", {mem_req, fifo_wr, done_irq}, 0);
    chk(cmd_err == 1'b0, "R1", "error clear", 32'(cmd_err), 32'd0);

    // R10: command with enable clear does nothing
    program_blk(24'h000400, 16'd4);
    req_cycles = 0;
    issue_cmd(24'h000400, 16'd4, 8'h01);
    repeat (20) @(negedge clk);
    chk(req_cycles == 0, "R10", "no request when disabled", 32'(req_cycles), 32'd0);
    chk(cmd_err == 1'b0, "R10", "error untouched", 32'(cmd_err), 32'd0);

    wr_reg(3'd5, 8'h01);
    en_model = 1;

    // R3 R5 plain command, free FIFO
    run_blk(24'h001000, 16'd5, 8'h01, "R3");
    // R6 R5 end of message with heavy FIFO back-pressure
    full_pct = 60;
    run_blk(24'h123456, 16'd17, 8'h02, "R5");
    full_pct = 25;
    // R6 single byte block with end of message
    run_blk(24'h00ABCD, 16'd1, 8'h02, "R6");
    // R3 address wrap modulo 2^24
    run_blk(24'hFFFFFD, 16'd6, 8'h02, "R3");
    // R2 both command bits: end of message wins
    run_blk(24'h070000, 16'd3, 8'h03, "R2");

    // R8: zero length
    req_cycles = 0;
    run_blk(24'h005000, 16'd0, 8'h02, "R8");
    chk(req_cycles == 0, "R8", "no request for zero length", 32'(req_cycles), 32'd0);
    chk(cmd_err == 1'b0, "R9", "no error so far", 32'(cmd_err), 32'd0);

    // R9: command during an active block
    full_pct = 50;
    program_blk(24'h200000, 16'd8);
    issue_cmd(24'h200000, 16'd8, 8'h01);
    issue_cmd(24'h300000, 16'd8, 8'h02);
    chk(cmd_err == 1'b1, "R9", "busy command flagged", 32'(cmd_err), 32'd1);
    wait_idle(8, "R9");
    chk(cmd_err == 1'b1, "R9", "error sticky", 32'(cmd_err), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule